// File: doc/BRIEF.md
# Load-Level CPU Clock Selector

This block produces the control settings for the CPU clock: a source select, a secondary clock select bit and a divider code. It does not generate a clock. A downstream mux and divider use these settings. The settings come from one of two places. In dynamic mode, a 2-bit current-level register points at one of four configuration slots, and the outputs follow that slot. In static mode, two plain fields give the source and the divider, and the slot table is bypassed.

Software programs the block through a simple register write port and a combinational read port. It can also ask for a rate change by presenting a divider code on a request pulse. The block then searches the four slots for a matching divider. If it finds one, it moves the current level to that slot and acknowledges. If not, it refuses the request. A level change that reaches the outputs raises a one-cycle strobe. A slot or static field with an illegal divider code is never applied: the outputs hold their last value and a sticky error flag is set.

Top module: `cpu_clk_lvl_sel`

## Requirements
- R1: After reset the outputs are src_sel=0, clk_sel=0, div_code=1, cfg_err=0, level_changed=0, rate_ack=0 and rate_nak=0. The current level reads 0, the static divider field reads 1, and all other registers read 0.
- R2: Registers are written by wr_en/wr_addr/wr_data and read combinationally through rd_addr/rd_data. The byte offsets are: static source 0x00 (bits 1:0), static divider 0x04 (bits 2:0), slot pair A 0x18 (32 bits), slot pair B 0x1C (32 bits), mode 0x30-free register 0x24 (bit 31 is the dynamic enable), current level 0x30 (bits 1:0). Any other offset reads 0.
- R3: Levels 0 and 1 live in pair A and levels 2 and 3 in pair B. The even level takes bits 31:16 and the odd level bits 15:0. Inside a 16-bit half the divider code is bits 15:13, the clock select is bit 11 and the source select is bits 10:9.
- R4: With the dynamic enable set, the outputs take the fields of the slot named by the current level. They update on the clock edge after the level register changes, with all three outputs changing in the same cycle.
- R5: With the dynamic enable clear, src_sel follows the static source field, div_code follows the static divider field, and clk_sel is 0.
- R6: The static fields have no effect on the outputs in dynamic mode, and the slot contents and current level have no effect in static mode.
- R7: level_changed is high for exactly the one cycle in which the outputs first show a slot whose level differs from the level last applied in dynamic mode (0 after reset). It is never high in static mode.
- R8: A selected divider code of 0 or 7 is illegal. The outputs keep their previous values, no strobe is raised, and cfg_err goes high and stays high until reset. Legal codes are 1 to 6.
- R9: A rate_req pulse with a legal code in dynamic mode searches the slots from level 0 upward. The lowest level whose divider equals rate_div is written into the current-level register, and rate_ack pulses in the following cycle.
- R10: A rate_req is refused with a one-cycle rate_nak, and the current level left unchanged, when no slot matches, when dynamic mode is off, or when rate_div is 0 or 7. rate_ack and rate_nak are never high together.
- R11: When a rate_req that is accepted arrives in the same cycle as a register write to the current level, the level chosen by the request is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| rate_req | input | 1 | Rate change request pulse |
| rate_div | input | 3 | Requested divider code |
| rate_ack | output | 1 | Request accepted, level moved |
| rate_nak | output | 1 | Request refused |
| src_sel | output | 2 | Clock source select |
| clk_sel | output | 1 | Secondary clock select |
| div_code | output | 3 | Divider code, always 1 to 6 |
| level_changed | output | 1 | One-cycle strobe on an applied level change |
| cfg_err | output | 1 | Sticky flag: an illegal divider was selected |

## Verification
The hardest case to reach from the ports is an illegal divider in a live slot while dynamic mode is running. The bench creates it by rewriting one half of a slot-pair register while another level is applied, then moving the current level onto the corrupted slot. It then checks that the outputs stay frozen and that no strobe appears. Two other cases are set up on purpose: the lowest-level priority of the rate search, by giving two slots the same divider, and the collision between a request and a direct level write, by driving both in the same cycle.

// File: rtl/cls_pkg.sv
package cls_pkg;
  localparam int REG_W      = 32;
  localparam int HALF_W     = 16;
  localparam int LVL_W      = 2;
  localparam int NUM_LVL    = 1 << LVL_W;
  localparam int SRC_W      = 2;
  localparam int DIV_W      = 3;

  localparam int SLOT_DIV_LSB = 13;
  localparam int SLOT_CLK_BIT = 11;
  localparam int SLOT_SRC_LSB = 9;
  localparam int DYN_EN_BIT   = 31;

  localparam int OFS_STAT_SRC = 'h00;
  localparam int OFS_STAT_DIV = 'h04;
  localparam int OFS_PAIR_A   = 'h18;
  localparam int OFS_PAIR_B   = 'h1C;
  localparam int OFS_MODE     = 'h24;
  localparam int OFS_LEVEL    = 'h30;

  localparam logic [DIV_W-1:0] DIV_MAX = DIV_W'(6);

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic             clk;
    logic [DIV_W-1:0] div;
  } lvl_cfg_t;

  function automatic logic div_ok(input logic [DIV_W-1:0] d);
    return (d != '0) && (d <= DIV_MAX);
  endfunction

  function automatic lvl_cfg_t unpack_half(input logic [HALF_W-1:0] h);
    lvl_cfg_t c;
    c.src = h[SLOT_SRC_LSB +: SRC_W];
    c.clk = h[SLOT_CLK_BIT];
    c.div = h[SLOT_DIV_LSB +: DIV_W];
    return c;
  endfunction
endpackage

// File: rtl/cls_regbank.sv
module cls_regbank
  import cls_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int RST_STAT_DIV = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              rate_req,
  input  logic              rate_hit,
  input  logic [LVL_W-1:0]  rate_lvl,
  output logic              rate_ack,
  output logic              rate_nak,
  output logic [SRC_W-1:0]  stat_src,
  output logic [DIV_W-1:0]  stat_div,
  output logic [REG_W-1:0]  pair_a,
  output logic [REG_W-1:0]  pair_b,
  output logic              dyn_en,
  output logic [LVL_W-1:0]  cur_lvl
);
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(OFS_STAT_SRC);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(OFS_STAT_DIV);
  localparam logic [ADDR_W-1:0] A_PA   = ADDR_W'(OFS_PAIR_A);
  localparam logic [ADDR_W-1:0] A_PB   = ADDR_W'(OFS_PAIR_B);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_LVL  = ADDR_W'(OFS_LEVEL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_src <= '0;
      stat_div <= DIV_W'(RST_STAT_DIV);
      pair_a   <= '0;
      pair_b   <= '0;
      dyn_en   <= 1'b0;
      cur_lvl  <= '0;
      rate_ack <= 1'b0;
      rate_nak <= 1'b0;
    end else begin
      rate_ack <= rate_req && rate_hit;
      rate_nak <= rate_req && !rate_hit;
      if (wr_en) begin
        case (wr_addr)
          A_SRC:   stat_src <= wr_data[SRC_W-1:0];
          A_DIV:   stat_div <= wr_data[DIV_W-1:0];
          A_PA:    pair_a   <= wr_data;
          A_PB:    pair_b   <= wr_data;
          A_MODE:  dyn_en   <= wr_data[DYN_EN_BIT];
          A_LVL:   cur_lvl  <= wr_data[LVL_W-1:0];
          default: ;
        endcase
      end
      // an accepted request overrides a same-cycle level write (R11)
      if (rate_req && rate_hit) cur_lvl <= rate_lvl;
    end
  end

  always_comb begin
    case (rd_addr)
      A_SRC:   rd_data = REG_W'(stat_src);
      A_DIV:   rd_data = REG_W'(stat_div);
      A_PA:    rd_data = pair_a;
      A_PB:    rd_data = pair_b;
      A_MODE:  rd_data = REG_W'(dyn_en) << DYN_EN_BIT;
      A_LVL:   rd_data = REG_W'(cur_lvl);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cls_slot_decode.sv
module cls_slot_decode
  import cls_pkg::*;
(
  input  logic [REG_W-1:0]              pair_a,
  input  logic [REG_W-1:0]              pair_b,
  input  logic [LVL_W-1:0]              cur_lvl,
  output lvl_cfg_t [NUM_LVL-1:0]        slots,
  output logic [NUM_LVL-1:0][DIV_W-1:0] slot_divs,
  output lvl_cfg_t                      cur_cfg
);
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_slot
    logic [REG_W-1:0]  word;
    logic [HALF_W-1:0] half;
    logic              unused_half;
    if (g < NUM_LVL / 2) begin : g_lo
      assign word = pair_a;
    end else begin : g_hi
      assign word = pair_b;
    end
    if ((g % 2) == 0) begin : g_even
      assign half = word[HALF_W +: HALF_W];
    end else begin : g_odd
      assign half = word[HALF_W-1:0];
    end
    assign unused_half  = ^half;
    assign slots[g]     = unpack_half(half);
    assign slot_divs[g] = slots[g].div;
  end

  assign cur_cfg = slots[cur_lvl];
endmodule

// File: rtl/cls_rate_match.sv
module cls_rate_match
  import cls_pkg::*;
(
  input  logic                          dyn_en,
  input  logic [DIV_W-1:0]              req_div,
  input  logic [NUM_LVL-1:0][DIV_W-1:0] slot_divs,
  output logic                          hit,
  output logic [LVL_W-1:0]              hit_lvl
);
  always_comb begin
    hit     = 1'b0;
    hit_lvl = '0;
    // walk from the top so the lowest matching level is kept last
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (slot_divs[i] == req_div) begin
        hit     = 1'b1;
        hit_lvl = LVL_W'(i);
      end
    end
    if (!dyn_en || !div_ok(req_div)) hit = 1'b0;
  end
endmodule

// File: rtl/cls_out_stage.sv
module cls_out_stage
  import cls_pkg::*;
#(
  parameter int RST_STAT_DIV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dyn_en,
  input  logic [LVL_W-1:0] cur_lvl,
  input  lvl_cfg_t         cur_cfg,
  input  logic [SRC_W-1:0] stat_src,
  input  logic [DIV_W-1:0] stat_div,
  output logic [SRC_W-1:0] src_sel,
  output logic             clk_sel,
  output logic [DIV_W-1:0] div_code,
  output logic             level_changed,
  output logic             cfg_err
);
  lvl_cfg_t         pick;
  logic             pick_ok;
  logic [LVL_W-1:0] applied_lvl;

  always_comb begin
    if (dyn_en) begin
      pick = cur_cfg;
    end else begin
      pick.src = stat_src;
      pick.clk = 1'b0;
      pick.div = stat_div;
    end
    pick_ok = div_ok(pick.div);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_sel       <= '0;
      clk_sel       <= 1'b0;
      div_code      <= DIV_W'(RST_STAT_DIV);
      level_changed <= 1'b0;
      cfg_err       <= 1'b0;
      applied_lvl   <= '0;
    end else begin
      level_changed <= 1'b0;
      if (pick_ok) begin
        src_sel  <= pick.src;
        clk_sel  <= pick.clk;
        div_code <= pick.div;
        if (dyn_en) begin
          applied_lvl   <= cur_lvl;
          level_changed <= (cur_lvl != applied_lvl);
        end
      end else begin
        cfg_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpu_clk_lvl_sel.sv
module cpu_clk_lvl_sel
  import cls_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int RST_STAT_DIV = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              rate_req,
  input  logic [2:0]        rate_div,
  output logic              rate_ack,
  output logic              rate_nak,
  output logic [1:0]        src_sel,
  output logic              clk_sel,
  output logic [2:0]        div_code,
  output logic              level_changed,
  output logic              cfg_err
);
  logic [SRC_W-1:0]              stat_src;
  logic [DIV_W-1:0]              stat_div;
  logic [REG_W-1:0]              pair_a;
  logic [REG_W-1:0]              pair_b;
  logic                          dyn_en;
  logic [LVL_W-1:0]              cur_lvl;
  lvl_cfg_t [NUM_LVL-1:0]        slots;
  logic [NUM_LVL-1:0][DIV_W-1:0] slot_divs;
  lvl_cfg_t                      cur_cfg;
  logic                          rate_hit;
  logic [LVL_W-1:0]              rate_lvl;
  logic                          unused_slots;

  assign unused_slots = ^slots;

  cls_regbank #(.ADDR_W(ADDR_W), .RST_STAT_DIV(RST_STAT_DIV)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .rate_req(rate_req), .rate_hit(rate_hit), .rate_lvl(rate_lvl),
    .rate_ack(rate_ack), .rate_nak(rate_nak),
    .stat_src(stat_src), .stat_div(stat_div),
    .pair_a(pair_a), .pair_b(pair_b),
    .dyn_en(dyn_en), .cur_lvl(cur_lvl)
  );

  cls_slot_decode u_dec (
    .pair_a(pair_a), .pair_b(pair_b), .cur_lvl(cur_lvl),
    .slots(slots), .slot_divs(slot_divs), .cur_cfg(cur_cfg)
  );

  cls_rate_match u_match (
    .dyn_en(dyn_en), .req_div(rate_div), .slot_divs(slot_divs),
    .hit(rate_hit), .hit_lvl(rate_lvl)
  );

  cls_out_stage #(.RST_STAT_DIV(RST_STAT_DIV)) u_out (
    .clk(clk), .rst_n(rst_n),
    .dyn_en(dyn_en), .cur_lvl(cur_lvl), .cur_cfg(cur_cfg),
    .stat_src(stat_src), .stat_div(stat_div),
    .src_sel(src_sel), .clk_sel(clk_sel), .div_code(div_code),
    .level_changed(level_changed), .cfg_err(cfg_err)
  );
endmodule

// File: rtl/cls_chk.sv
module cls_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dyn_en,
  input logic       rate_req,
  input logic       rate_ack,
  input logic       rate_nak,
  input logic [1:0] src_sel,
  input logic       clk_sel,
  input logic [2:0] div_code,
  input logic       level_changed,
  input logic       cfg_err
);
  a_r8_div_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (div_code != 3'd0) && (div_code <= 3'd6));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  a_r8_hold_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> ($stable(div_code) && $stable(src_sel) && $stable(clk_sel)));

  a_r7_strobe_dyn_only: assert property (@(posedge clk) disable iff (!rst_n)
    level_changed |-> $past(dyn_en));

  a_r9_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_ack || rate_nak) |-> $past(rate_req));

  a_r10_resp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rate_ack && rate_nak));

  a_r10_nak_static: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_req && !dyn_en) |=> rate_nak);
endmodule

bind cpu_clk_lvl_sel cls_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dyn_en(dyn_en),
  .rate_req(rate_req), .rate_ack(rate_ack), .rate_nak(rate_nak),
  .src_sel(src_sel), .clk_sel(clk_sel), .div_code(div_code),
  .level_changed(level_changed), .cfg_err(cfg_err)
);

// File: tb/cpu_clk_lvl_sel_tb_top.sv
module cpu_clk_lvl_sel_tb_top;
  localparam int AW = 8;
  localparam logic [AW-1:0] A_SRC = 8'h00, A_DIV = 8'h04, A_PA = 8'h18,
                            A_PB = 8'h1C, A_MODE = 8'h24, A_LVL = 8'h30;
  localparam logic [31:0] DYN_ON = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic rate_req = 1'b0;
  logic [2:0] rate_div = '0;
  logic rate_ack, rate_nak, clk_sel, level_changed, cfg_err;
  logic [1:0] src_sel;
  logic [2:0] div_code;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cpu_clk_lvl_sel #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rate_req(rate_req), .rate_div(rate_div),
    .rate_ack(rate_ack), .rate_nak(rate_nak), .src_sel(src_sel), .clk_sel(clk_sel),
    .div_code(div_code), .level_changed(level_changed), .cfg_err(cfg_err)
  );

  // {level, src, clk, div, strobe}
  localparam logic [8:0] VEC [0:4] = '{
    {2'd2, 2'd3, 1'b1, 3'd6, 1'b1},
    {2'd2, 2'd3, 1'b1, 3'd6, 1'b0},
    {2'd1, 2'd1, 1'b0, 3'd2, 1'b1},
    {2'd3, 2'd0, 1'b0, 3'd1, 1'b1},
    {2'd0, 2'd2, 1'b1, 3'd3, 1'b1}
  };

  function automatic logic [15:0] slot16(input int s, input int c, input int d);
    return 16'((d << 13) | (c << 11) | (s << 9));
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic req(input logic [2:0] dv);
    @(negedge clk);
    rate_req = 1'b1; rate_div = dv;
    @(negedge clk);
    rate_req = 1'b0;
  endtask

  task automatic outs(input string tag, input int s, input int c, input int d);
    chk({tag, " src"}, src_sel, s);
    chk({tag, " clk"}, clk_sel, c);
    chk({tag, " div"}, div_code, d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [31:0] p01, p23;
    p01 = {slot16(2, 1, 3), slot16(1, 0, 2)};
    p23 = {slot16(3, 1, 6), slot16(0, 0, 1)};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    outs("R1 reset", 0, 0, 1);
    chk("R1 err", cfg_err, 0);
    chk("R1 strobe", level_changed, 0);
    chk("R1 ack", rate_ack, 0);
    chk("R1 nak", rate_nak, 0);
    rd(A_LVL, r); chk("R1 level", r, 0);
    rd(A_DIV, r); chk("R1 stat div", r, 1);

    // R2 register access
    wr(A_PA, p01);
    rd(A_PA, r); chk("R2 pair A readback", r, p01);
    rd(8'h08, r); chk("R2 unmapped", r, 0);

    // R5 static mode
    wr(A_SRC, 32'd2);
    wr(A_DIV, 32'd5);
    @(negedge clk);
    outs("R5 static", 2, 0, 5);

    // R3/R4 enable dynamic with level 0
    wr(A_PB, p23);
    wr(A_MODE, DYN_ON);
    rd(A_MODE, r); chk("R2 mode readback", r, DYN_ON);
    @(negedge clk);
    outs("R4 level0", 2, 1, 3);
    chk("R7 no strobe same level", level_changed, 0);

    // R3/R4/R7 vector walk
    foreach (VEC[i]) begin
      wr(A_LVL, 32'(VEC[i][8:7]));
      @(negedge clk);
      outs($sformatf("R3 vec%0d", i), VEC[i][6:5], VEC[i][4], VEC[i][3:1]);
      chk($sformatf("R7 vec%0d strobe", i), level_changed, VEC[i][0]);
      if (i == 0) begin
        @(negedge clk);
        chk("R7 strobe one cycle", level_changed, 0);
      end
    end

    // R6 static fields ignored in dynamic mode, slots ignored in static mode
    wr(A_SRC, 32'd1);
    wr(A_DIV, 32'd2);
    @(negedge clk);
    outs("R6 dyn ignores static", 2, 1, 3);
    wr(A_MODE, 32'd0);
    @(negedge clk);
    outs("R6 static ignores slots", 1, 0, 2);
    wr(A_LVL, 32'd2);
    @(negedge clk);
    outs("R6 level ignored static", 1, 0, 2);
    chk("R7 no strobe static", level_changed, 0);
    wr(A_LVL, 32'd0);

    // R10 refused while static
    req(3'd3);
    chk("R10 nak static", rate_nak, 1);
    chk("R10 no ack static", rate_ack, 0);
    rd(A_LVL, r); chk("R10 level kept static", r, 0);

    // R9 accepted request
    wr(A_MODE, DYN_ON);
    @(negedge clk);
    req(3'd6);
    chk("R9 ack", rate_ack, 1);
    chk("R9 no nak", rate_nak, 0);
    rd(A_LVL, r); chk("R9 level set", r, 2);
    @(negedge clk);
    outs("R9 outputs", 3, 1, 6);
    chk("R9 strobe", level_changed, 1);

    // R10 no match / illegal codes
    req(3'd4);
    chk("R10 nak nomatch", rate_nak, 1);
    rd(A_LVL, r); chk("R10 level kept", r, 2);
    req(3'd0);
    chk("R10 nak code0", rate_nak, 1);
    req(3'd7);
    chk("R10 nak code7", rate_nak, 1);
    chk("R10 ack low", rate_ack, 0);

    // R9 lowest level wins on duplicate divider
    wr(A_PB, {slot16(3, 1, 6), slot16(0, 0, 3)});
    req(3'd3);
    chk("R9 dup ack", rate_ack, 1);
    rd(A_LVL, r); chk("R9 lowest level", r, 0);

    // R11 request beats same-cycle level write
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_LVL; wr_data = 32'd1;
    rate_req = 1'b1; rate_div = 3'd6;
    @(negedge clk);
    wr_en = 1'b0; rate_req = 1'b0;
    chk("R11 ack", rate_ack, 1);
    rd(A_LVL, r); chk("R11 level", r, 2);
    @(negedge clk);
    outs("R11 outputs", 3, 1, 6);

    // R8 illegal divider in a live slot
    wr(A_PA, {slot16(2, 1, 3), slot16(1, 0, 7)});
    wr(A_LVL, 32'd1);
    @(negedge clk);
    chk("R8 err set", cfg_err, 1);
    outs("R8 hold", 3, 1, 6);
    chk("R8 no strobe", level_changed, 0);
    wr(A_LVL, 32'd0);
    @(negedge clk);
    outs("R8 recover", 2, 1, 3);
    chk("R8 err sticky", cfg_err, 1);
    chk("R7 strobe after recover", level_changed, 1);

    finish_run();
  end
endmodule